// File: doc/BRIEF.md
# Eigenvalue-to-Angle Converter

This block turns the rotation eigenvalues found by a subspace direction finder into arrival angles. It assumes a uniform linear array whose element spacing is half a wavelength, so the arccos argument is simply the eigenvalue's phase divided by pi. Each of the two lanes does three things in order. A pipelined vectoring CORDIC, with a quadrant pre-rotation, measures the phase over the full circle. The phase is then clamped to [-pi, pi] and quantized to a table index. Finally a block-RAM style table of precomputed inverse cosines gives the angle in degrees.

Both eigenvalues arrive together with a single valid strobe, and the block accepts a new pair every clock cycle. A flag marks whether a second source is present. When it is not, the second angle output is forced to zero. The two angles leave together with a one-cycle valid strobe at a fixed latency.

Top module: `doa_angle_conv`

## Requirements
- R1: For lane A, `angle_a` equals table entry k or an adjacent entry (k-1 or k+1), where k = round((arg(a)/pi + 1) * 255 / 2) and arg is the four-quadrant phase in (-pi, pi].
- R2: Lane B follows the same rule for `angle_b` from (b_re, b_im), independently of lane A, whenever `in_dual` was 1.
- R3: The table has 256 entries. Entry i is round(acos(-1 + 2i/255) * 180/pi * 128). Angles are unsigned 16-bit values with 7 fractional bits, so they never exceed 23040 (180 degrees).
- R4: An eigenvalue on the negative real axis (imaginary part 0, real part negative) has phase +pi and yields exactly 0, since the phase is clamped to at most +pi.
- R5: An eigenvalue just below the negative real axis (real part negative, small negative imaginary part) yields exactly 23040 (180 degrees).
- R6: The result depends only on direction. Raw magnitudes from 300 to 20000 LSB meet the R1/R2 tolerance.
- R7: `out_valid` pulses for exactly one cycle, 18 clock cycles (CORDIC iterations + 4) after the cycle in which `in_valid` was sampled high. Back-to-back inputs each give one output, in order.
- R8: When `in_dual` was 0 for an input, `angle_b` is 0 in the cycle its result is valid.
- R9: While `rst` is high, `out_valid`, `angle_a` and `angle_b` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Eigenvalue pair valid |
| in_dual | input | 1 | 1 when a second source is present |
| a_re | input | 16 | Lane A eigenvalue, real part, signed |
| a_im | input | 16 | Lane A eigenvalue, imaginary part, signed |
| b_re | input | 16 | Lane B eigenvalue, real part, signed |
| b_im | input | 16 | Lane B eigenvalue, imaginary part, signed |
| out_valid | output | 1 | One-cycle strobe, both angles ready |
| angle_a | output | 16 | Lane A angle, degrees, 7 fractional bits |
| angle_b | output | 16 | Lane B angle, degrees, 7 fractional bits |

## Verification
The bench sweeps both lanes around the full circle in 5-degree steps at three magnitudes, streamed back to back. This sweep catches a wrong quadrant pre-rotation, which would fold angles onto the wrong half-plane. It also catches a skipped CORDIC stage, which would drift past the one-index tolerance at small magnitudes.

The cut on the negative real axis is probed from both sides. If the clamp is missing, or the pre-rotation sends a zero imaginary part the wrong way, the output reads 180 degrees where 0 is expected, or the reverse.

Single-source inputs are mixed into the stream, and a lone input measures latency and pulse width. A design that leaked lane B or miscounted its pipeline would therefore show stray angles or a shifted strobe.

// File: rtl/doa_pkg.sv
`timescale 1ns/1ps
package doa_pkg;
  localparam real PI_R = 3.14159265358979323846;

  // Elementary rotation angle atan(2^-i), scaled so that pi maps to 2^pf.
  function automatic int atan_step(input int i, input int pf);
    return $rtoi($atan(2.0 ** (-i)) / PI_R * (2.0 ** pf) + 0.5);
  endfunction

  // Inverse cosine table entry in degrees with af fractional bits.
  function automatic int acos_entry(input int i, input int depth, input int af);
    real xv;
    xv = -1.0 + 2.0 * i / (depth - 1);
    if (xv > 1.0)  xv = 1.0;
    if (xv < -1.0) xv = -1.0;
    return $rtoi($acos(xv) * 180.0 / PI_R * (2.0 ** af) + 0.5);
  endfunction
endpackage

// File: rtl/doa_cordic_phase.sv
`timescale 1ns/1ps
// Pipelined vectoring CORDIC: one pre-rotation stage, then ITER iteration stages.
// Output phase is signed, with pi represented by 2^PF.
module doa_cordic_phase #(
  parameter int W    = 16,
  parameter int ITER = 14,
  parameter int PF   = 14
) (
  input  logic                clk,
  input  logic signed [W-1:0] in_re,
  input  logic signed [W-1:0] in_im,
  output logic signed [PF+2:0] phase_o
);
  import doa_pkg::*;
  localparam int XW = W + 2;
  localparam int ZW = PF + 3;
  localparam logic signed [ZW-1:0] HALF_PI = ZW'(2 ** (PF - 1));

  logic signed [XW-1:0] xs [ITER-1];
  logic signed [XW-1:0] ys [ITER-1];
  logic signed [ZW-1:0] zs [ITER+1];
  logic                 yneg [ITER];
  logic                 last_neg;

  // Quadrant pre-rotation into the right half-plane.
  logic signed [XW-1:0] x0_q, y0_q;
  logic signed [ZW-1:0] z0_q;
  always_ff @(posedge clk) begin
    if (in_re < 0) begin
      if (in_im >= 0) begin
        x0_q <= XW'(in_im);
        y0_q <= -XW'(in_re);
        z0_q <= HALF_PI;
      end else begin
        x0_q <= -XW'(in_im);
        y0_q <= XW'(in_re);
        z0_q <= -HALF_PI;
      end
    end else begin
      x0_q <= XW'(in_re);
      y0_q <= XW'(in_im);
      z0_q <= '0;
    end
  end
  assign xs[0] = x0_q;
  assign ys[0] = y0_q;
  assign zs[0] = z0_q;

  for (genvar i = 0; i < ITER; i++) begin : g_sign
    if (i < ITER - 1) begin : g_full
      assign yneg[i] = (ys[i] < 0);
    end else begin : g_last
      assign yneg[i] = last_neg;
    end
  end

  for (genvar i = 0; i < ITER; i++) begin : g_st
    localparam logic signed [ZW-1:0] ANG = ZW'(atan_step(i, PF));
    logic signed [ZW-1:0] z_q;
    always_ff @(posedge clk) z_q <= yneg[i] ? zs[i] - ANG : zs[i] + ANG;
    assign zs[i+1] = z_q;

    if (i < ITER - 2) begin : g_xy
      logic signed [XW-1:0] x_q, y_q;
      always_ff @(posedge clk) begin
        if (yneg[i]) begin
          x_q <= xs[i] - (ys[i] >>> i);
          y_q <= ys[i] + (xs[i] >>> i);
        end else begin
          x_q <= xs[i] + (ys[i] >>> i);
          y_q <= ys[i] - (xs[i] >>> i);
        end
      end
      assign xs[i+1] = x_q;
      assign ys[i+1] = y_q;
    end else if (i == ITER - 2) begin : g_ysign
      logic signed [XW-1:0] y_nx;
      logic                 n_q;
      always_comb y_nx = yneg[i] ? ys[i] + (xs[i] >>> i) : ys[i] - (xs[i] >>> i);
      always_ff @(posedge clk) n_q <= (y_nx < 0);
      assign last_neg = n_q;
    end
  end

  assign phase_o = zs[ITER];
endmodule

// File: rtl/doa_phase_index.sv
`timescale 1ns/1ps
// Clamp the phase to [-pi, pi] and round (phase/pi + 1)*(DEPTH-1)/2 to an index.
module doa_phase_index #(
  parameter int PF = 14,
  parameter int IW = 8
) (
  input  logic                 clk,
  input  logic signed [PF+2:0] phase_i,
  output logic [IW-1:0]        idx_o
);
  localparam int ZW    = PF + 3;
  localparam int UW    = PF + 2;
  localparam int PRW   = PF + IW + 2;
  localparam int DEPTH = 2 ** IW;
  localparam logic signed [ZW-1:0] PI_Q = ZW'(2 ** PF);

  logic signed [ZW-1:0] clamped;
  logic [UW-1:0]        u;
  logic [PRW-1:0]       prod;

  always_comb begin
    if (phase_i > PI_Q)       clamped = PI_Q;
    else if (phase_i < -PI_Q) clamped = -PI_Q;
    else                      clamped = phase_i;
    u    = UW'(clamped + PI_Q);
    prod = PRW'(u) * PRW'(DEPTH - 1) + PRW'(2 ** PF);
  end

  always_ff @(posedge clk) idx_o <= IW'(prod >> (PF + 1));
endmodule

// File: rtl/doa_acos_rom.sv
`timescale 1ns/1ps
// Registered-read inverse cosine table, written for block RAM inference.
module doa_acos_rom #(
  parameter int IW = 8,
  parameter int AW = 16,
  parameter int AF = 7
) (
  input  logic          clk,
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] ang_o
);
  import doa_pkg::*;
  localparam int DEPTH = 2 ** IW;

  logic [AW-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) rom[i] = AW'(acos_entry(i, DEPTH, AF));
  end

  always_ff @(posedge clk) ang_o <= rom[idx];
endmodule

// File: rtl/doa_angle_conv.sv
`timescale 1ns/1ps
module doa_angle_conv #(
  parameter int W    = 16,
  parameter int ITER = 14,
  parameter int PF   = 14,
  parameter int IW   = 8,
  parameter int AW   = 16,
  parameter int AF   = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_dual,
  input  logic signed [W-1:0] a_re,
  input  logic signed [W-1:0] a_im,
  input  logic signed [W-1:0] b_re,
  input  logic signed [W-1:0] b_im,
  output logic                out_valid,
  output logic [AW-1:0]       angle_a,
  output logic [AW-1:0]       angle_b
);
  localparam int NLANE = 2;
  // pre-rotation + iterations + index + table + output register
  localparam int LAT   = ITER + 4;

  logic signed [W-1:0] lane_re [NLANE];
  logic signed [W-1:0] lane_im [NLANE];
  logic [AW-1:0]       lane_ang [NLANE];

  assign lane_re[0] = a_re;
  assign lane_im[0] = a_im;
  assign lane_re[1] = b_re;
  assign lane_im[1] = b_im;

  for (genvar ln = 0; ln < NLANE; ln++) begin : g_lane
    logic signed [PF+2:0] phase;
    logic [IW-1:0]        idx;
    doa_cordic_phase #(.W(W), .ITER(ITER), .PF(PF)) u_cordic (
      .clk(clk), .in_re(lane_re[ln]), .in_im(lane_im[ln]), .phase_o(phase));
    doa_phase_index #(.PF(PF), .IW(IW)) u_index (
      .clk(clk), .phase_i(phase), .idx_o(idx));
    doa_acos_rom #(.IW(IW), .AW(AW), .AF(AF)) u_rom (
      .clk(clk), .idx(idx), .ang_o(lane_ang[ln]));
  end

  logic [LAT-2:0] vpipe, dpipe;
  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe <= '0;
      dpipe <= '0;
    end else begin
      vpipe <= {vpipe[LAT-3:0], in_valid};
      dpipe <= {dpipe[LAT-3:0], in_dual};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      angle_a   <= '0;
      angle_b   <= '0;
    end else begin
      out_valid <= vpipe[LAT-2];
      angle_a   <= lane_ang[0];
      angle_b   <= dpipe[LAT-2] ? lane_ang[1] : '0;
    end
  end
endmodule

// File: rtl/doa_angle_conv_chk.sv
`timescale 1ns/1ps
module doa_angle_conv_chk #(
  parameter int LAT = 18,
  parameter int AW  = 16,
  parameter int AF  = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_dual,
  input logic          out_valid,
  input logic [AW-1:0] angle_a,
  input logic [AW-1:0] angle_b
);
  localparam logic [AW-1:0] MAX_ANG = AW'(180 * (2 ** AF));

  logic [LAT-1:0] ref_v, ref_d;
  always_ff @(posedge clk) begin
    if (rst) begin
      ref_v <= '0;
      ref_d <= '0;
    end else begin
      ref_v <= {ref_v[LAT-2:0], in_valid};
      ref_d <= {ref_d[LAT-2:0], in_dual};
    end
  end

  // R7: strobe tracks the accepted inputs at the fixed latency
  a_r7_valid_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == ref_v[LAT-1]);

  // R8: single-source results carry a zero second angle
  a_r8_single_b_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !ref_d[LAT-1]) |-> (angle_b == '0));

  // R3: angles stay within 0..180 degrees
  a_r3_range_a: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (angle_a <= MAX_ANG));

  a_r3_range_b: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (angle_b <= MAX_ANG));
endmodule

bind doa_angle_conv doa_angle_conv_chk #(.LAT(ITER + 4), .AW(AW), .AF(AF)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_dual(in_dual),
  .out_valid(out_valid), .angle_a(angle_a), .angle_b(angle_b));

// File: tb/doa_angle_conv_tb.sv
`timescale 1ns/1ps
module doa_angle_conv_tb;
  localparam int  LAT   = 18;
  localparam int  DEPTH = 256;
  localparam int  NV    = 220;
  localparam real PI_B  = 3.14159265358979323846;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic               in_valid = 1'b0, in_dual = 1'b0;
  logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic               out_valid;
  logic [15:0]        angle_a, angle_b;

  doa_angle_conv u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dual(in_dual),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid), .angle_a(angle_a), .angle_b(angle_b));

  int vre_a[NV], vim_a[NV], vre_b[NV], vim_b[NV];
  int vexa[NV], vexb[NV];
  bit vdual[NV], vsmall[NV];
  int checks = 0, fails = 0, nout = 0;
  bit done = 0;

  function automatic int tab(input int i);
    real xv;
    int  k;
    k = (i < 0) ? 0 : (i > DEPTH - 1) ? DEPTH - 1 : i;
    xv = -1.0 + 2.0 * k / (DEPTH - 1);
    if (xv > 1.0)  xv = 1.0;
    if (xv < -1.0) xv = -1.0;
    return $rtoi($acos(xv) * 180.0 / PI_B * 128.0 + 0.5);
  endfunction

  function automatic int near_idx(input int re, input int im);
    real p;
    p = $atan2(real'(im), real'(re)) / PI_B;
    return $rtoi($floor((p + 1.0) * (DEPTH - 1) / 2.0 + 0.5));
  endfunction

  task automatic check_ang(input string req, input int act, input int re, input int im);
    int  k;
    bit  ok;
    k  = near_idx(re, im);
    ok = 0;
    for (int d = -1; d <= 1; d++) begin
      int e;
      e = tab(k + d);
      if (act >= e - 1 && act <= e + 1) ok = 1;
    end
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: input (%0d,%0d) actual %0d expected %0d (+/-1 index)",
               req, re, im, act, tab(k));
    end
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (nout >= NV) begin
        check_eq("R7 spurious strobe", 1, 0);
      end else begin
        if (vexa[nout] >= 0) check_eq("R4 negative real axis", int'(angle_a), vexa[nout]);
        else check_ang(vsmall[nout] ? "R6 lane A small magnitude" : "R1 lane A",
                       int'(angle_a), vre_a[nout], vim_a[nout]);
        if (!vdual[nout]) check_eq("R8 single source lane B", int'(angle_b), 0);
        else if (vexb[nout] >= 0) check_eq("R5 below negative real axis", int'(angle_b), vexb[nout]);
        else check_ang("R2 lane B", int'(angle_b), vre_b[nout], vim_b[nout]);
      end
      nout++;
    end
  end

  task automatic drive(input int n);
    in_valid = 1'b1;
    in_dual  = vdual[n];
    a_re = 16'(vre_a[n]);
    a_im = 16'(vim_a[n]);
    b_re = 16'(vre_b[n]);
    b_im = 16'(vim_b[n]);
  endtask

  initial begin
    int mags[3];
    int k;
    mags[0] = 20000; mags[1] = 3000; mags[2] = 300;

    // Special vectors: R4 exact 0 on lane A, R5 exact 180 degrees on lane B.
    vre_a[0] = -20000; vim_a[0] = 0;  vexa[0] = 0;
    vre_b[0] = -20000; vim_b[0] = -1; vexb[0] = 23040;
    vre_a[1] = -3000;  vim_a[1] = 0;  vexa[1] = 0;
    vre_b[1] = -20000; vim_b[1] = -5; vexb[1] = 23040;
    vdual[0] = 1; vdual[1] = 1; vsmall[0] = 0; vsmall[1] = 0;
    for (int m = 0; m < 3; m++) begin
      for (int s = 0; s < 72; s++) begin
        int  n;
        real aa, ab;
        n  = 2 + m * 72 + s;
        aa = (s * 5.0 + 0.7) * PI_B / 180.0;
        ab = (s * 5.0 + 37.3) * PI_B / 180.0;
        vre_a[n] = $rtoi(mags[m] * $cos(aa));
        vim_a[n] = $rtoi(mags[m] * $sin(aa));
        vre_b[n] = $rtoi(mags[(m + 1) % 3] * $cos(ab));
        vim_b[n] = $rtoi(mags[(m + 1) % 3] * $sin(ab));
        vexa[n] = -1; vexb[n] = -1;
        vdual[n]  = (s % 5 != 0);
        vsmall[n] = (m == 2);
      end
    end
    vre_a[218] = 1000;  vim_a[218] = 2000; vre_b[218] = -7000; vim_b[218] = 9000;
    vre_a[219] = -4000; vim_a[219] = 1500; vre_b[219] = 5000;  vim_b[219] = -8000;
    for (int n = 218; n < NV; n++) begin
      vexa[n] = -1; vexb[n] = -1; vdual[n] = 1; vsmall[n] = 0;
    end

    // R9: reset state
    repeat (3) @(negedge clk);
    check_eq("R9 out_valid in reset", int'(out_valid), 0);
    check_eq("R9 angle_a in reset", int'(angle_a), 0);
    check_eq("R9 angle_b in reset", int'(angle_b), 0);
    @(negedge clk) rst = 1'b0;

    // Back-to-back stream (R1, R2, R4, R5, R6, R8)
    for (int n = 0; n < NV - 1; n++) begin
      @(negedge clk);
      drive(n);
    end
    @(negedge clk) in_valid = 1'b0;
    repeat (LAT + 5) @(negedge clk);
    check_eq("R7 one output per streamed input", nout, NV - 1);

    // R7: latency and pulse width of a lone input
    @(negedge clk);
    drive(NV - 1);
    @(negedge clk) in_valid = 1'b0;
    k = 1;
    while (!out_valid && k < 100) begin
      @(negedge clk);
      k++;
    end
    check_eq("R7 latency", k, LAT);
    @(negedge clk);
    check_eq("R7 one-cycle strobe", int'(out_valid), 0);
    repeat (4) @(negedge clk);
    check_eq("R7 total outputs", nout, NV);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule